// File: doc/BRIEF.md
# Multidrop Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial characters on a shared multidrop line. Each character carries a start bit, eight data bits sent least significant bit first, a ninth address-marker bit and a stop bit. The serial input is resynchronised and then sampled on an external 16x oversampling tick. Each bit is judged by a majority vote of three tick samples taken near its middle. A completed character is placed in a parallel holding register together with its marker bit, and the data-ready flag is raised. Framing-error and overrun flags are kept beside the holding register. An interrupt request follows data-ready when it is enabled.

A node can skip traffic that is meant for other nodes. Software raises a sleep flag, and while it is set finished characters are thrown away. Hardware clears the flag on one of two wake conditions, chosen by a mode input. In idle-line mode the condition is eleven bit times of a quiet high line. In address mode the condition is a character whose marker bit is 1, and that character is delivered. Software can clear the flag itself to wake the node at once. A soft reset pulse also clears it. The flag has no effect while the synchronous-mode input is high. The receiver-enable input only controls whether a new character may begin. A character already in progress always completes.

Top module: `mdrop_rx`

## Requirements
- R1: Frame timing and format. A character is a low start bit, eight data bits least significant first, an address-marker bit and a stop bit. Each bit lasts 16 `tick_i` pulses. On completion `data_o` takes the data byte, `addr_o` takes the marker bit and `ready_o` goes to 1.
- R2: Start qualification. A falling edge starts a character only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit leaves `ready_o` at 0 and does not disturb the next character.
- R3: Framing error. If the stop bit samples low, `fe_o` goes to 1, and the data byte and marker bit are still delivered.
- R4: Read and interrupt. A pulse on `rd_i` clears `ready_o`, `fe_o` and `ovr_o`. `irq_o` equals `ready_o` AND `irq_en_i` at all times, whatever the level of `rx_en_i`.
- R5: Overrun. If a character completes while `ready_o` is 1 and no read arrives in the same cycle, `ovr_o` goes to 1. `data_o` and `addr_o` keep the older character.
- R6: Enable. With `rx_en_i` at 0, no character starts and `ready_o` stays 0. If `rx_en_i` falls while a character is in progress, that character completes and is delivered.
- R7: Sleep flag control. A `sleep_set_i` pulse sets `sleep_o` and a `sleep_clr_i` pulse clears it. When both pulse together, set wins. `soft_rst_i` clears `sleep_o` and overrides both.
- R8: Idle-line wake (`wake_sel_i`=0). While `sleep_o` is 1, completed characters are discarded. Once the line has stayed high for 11 bit times (176 ticks) with no character in progress, `sleep_o` clears and the next character is delivered. After 8 quiet bit times `sleep_o` is still 1.
- R9: Address wake (`wake_sel_i`=1). While `sleep_o` is 1, characters with marker bit 0 are discarded and an idle line does not wake the node. A character with marker bit 1 clears `sleep_o` and is itself delivered.
- R10: Synchronous mode. With `sync_mode_i`=1 the sleep flag has no effect: every character is delivered. Neither wake condition clears `sleep_o`.
- R11: Majority vote. A disturbance lasting one tick inside a data bit does not change the received value of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Soft reset pulse; clears the sleep flag |
| tick_i | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Permits new characters to start |
| wake_sel_i | input | 1 | Wake condition: 0 idle line, 1 address marker |
| sync_mode_i | input | 1 | Synchronous mode; sleep flag ignored |
| sleep_set_i | input | 1 | Sets the sleep flag |
| sleep_clr_i | input | 1 | Clears the sleep flag |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Holding-register read strobe |
| data_o | output | 8 | Received data byte |
| addr_o | output | 1 | Received address-marker bit |
| ready_o | output | 1 | Data ready |
| fe_o | output | 1 | Framing error |
| ovr_o | output | 1 | Overrun |
| sleep_o | output | 1 | Sleep flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The assertions assume that `rd_i`, `sleep_set_i`, `sleep_clr_i` and `soft_rst_i` are single-cycle strobes. They also assume that `tick_i` pulses at no more than one per clock, so a completed character appears as a one-cycle event the flags can be related to. The stimulus drives every control strobe for exactly one clock and changes the mode inputs only while the line is idle. It generates the tick as a steady divide-by-two of the clock, so each bit lasts exactly 32 clocks. Injected glitches and short start pulses are placed away from the sampling window edges, so one result is expected whatever the synchroniser delay.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/mdrop_rx_sampler.sv
module mdrop_rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic tick_i,
  output logic line_o,
  output logic vote_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end

  assign line_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_q <= '1;
    else if (tick_i) hist_q <= {hist_q[1:0], line_o};
  end

  assign vote_o = mdrop_pkg::maj3(hist_q);
endmodule

// File: rtl/mdrop_rx_framer.sv
module mdrop_rx_framer
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              vote_i,
  input  logic              en_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              addr_o,
  output logic              stop_o
);
  localparam int SH_W = DATA_W + 1;
  localparam int TCW  = $clog2(OSR);
  localparam int BCW  = $clog2(SH_W + 1);
  localparam logic [TCW-1:0] T_HALF = TCW'(OSR / 2 - 1);
  localparam logic [TCW-1:0] T_LAST = TCW'(OSR - 1);
  localparam logic [BCW-1:0] B_STOP = BCW'(SH_W);

  rx_state_e       state_q;
  logic [TCW-1:0]  tcnt_q;
  logic [BCW-1:0]  bcnt_q;
  logic [SH_W-1:0] sh_q;
  logic            done_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (!line_i && en_i) begin
            state_q <= RX_START;
            tcnt_q  <= '0;
          end
          RX_START: begin
            if (tcnt_q == T_HALF) begin
              if (vote_i) state_q <= RX_IDLE;  // false start
              else begin
                state_q <= RX_BITS;
                tcnt_q  <= '0;
                bcnt_q  <= '0;
              end
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          RX_BITS: begin
            if (tcnt_q == T_LAST) begin
              tcnt_q <= '0;
              if (bcnt_q == B_STOP) begin
                done_q  <= 1'b1;
                stop_q  <= vote_i;
                state_q <= RX_IDLE;
              end else begin
                sh_q   <= {vote_i, sh_q[SH_W-1:1]};
                bcnt_q <= bcnt_q + 1'b1;
              end
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != RX_IDLE);
  assign done_o = done_q;
  assign data_o = sh_q[DATA_W-1:0];
  assign addr_o = sh_q[SH_W-1];
  assign stop_o = stop_q;
endmodule

// File: rtl/mdrop_idle_det.sv
module mdrop_idle_det #(
  parameter int LIMIT = 176
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic busy_i,
  output logic idle_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] C_MAX  = CW'(LIMIT);
  localparam logic [CW-1:0] C_NEAR = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      idle_q <= 1'b0;
      if (busy_i || !line_i) cnt_q <= '0;
      else if (tick_i && cnt_q != C_MAX) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == C_NEAR) idle_q <= 1'b1;
      end
    end
  end

  assign idle_o = idle_q;
endmodule

// File: rtl/mdrop_wake_ctrl.sv
module mdrop_wake_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic hw_wake_i,
  output logic sleep_o
);
  logic sleep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sleep_q <= 1'b0;
    else if (soft_rst_i)         sleep_q <= 1'b0;
    else if (set_i)              sleep_q <= 1'b1;
    else if (clr_i || hw_wake_i) sleep_q <= 1'b0;
  end

  assign sleep_o = sleep_q;
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_BITS   = DATA_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic              wake_sel_i,
  input  logic              sync_mode_i,
  input  logic              sleep_set_i,
  input  logic              sleep_clr_i,
  input  logic              irq_en_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              addr_o,
  output logic              ready_o,
  output logic              fe_o,
  output logic              ovr_o,
  output logic              sleep_o,
  output logic              irq_o
);
  localparam int IDLE_TICKS = IDLE_BITS * OSR;

  logic              line, vote, busy;
  logic              frame_done, frame_addr, frame_stop;
  logic [DATA_W-1:0] frame_data;
  logic              idle_pulse, sleep_q;
  logic              sleeping, hw_wake, accept, ready_held;
  logic [DATA_W-1:0] data_q;
  logic              addr_q, ready_q, fe_q, ovr_q;

  mdrop_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
    .clk_i, .rst_ni, .rx_i, .tick_i, .line_o(line), .vote_o(vote)
  );

  mdrop_rx_framer #(.DATA_W(DATA_W), .OSR(OSR)) i_framer (
    .clk_i, .rst_ni, .tick_i, .line_i(line), .vote_i(vote), .en_i(rx_en_i),
    .busy_o(busy), .done_o(frame_done), .data_o(frame_data),
    .addr_o(frame_addr), .stop_o(frame_stop)
  );

  mdrop_idle_det #(.LIMIT(IDLE_TICKS)) i_idle (
    .clk_i, .rst_ni, .tick_i, .line_i(line), .busy_i(busy), .idle_o(idle_pulse)
  );

  assign sleeping = sleep_q & ~sync_mode_i;
  assign hw_wake  = sleeping & (wake_sel_i ? (frame_done & frame_addr) : idle_pulse);

  mdrop_wake_ctrl i_wake (
    .clk_i, .rst_ni, .soft_rst_i, .set_i(sleep_set_i), .clr_i(sleep_clr_i),
    .hw_wake_i(hw_wake), .sleep_o(sleep_q)
  );

  // waking address frame is delivered, other frames are dropped while asleep
  assign accept     = frame_done & (~sleeping | (wake_sel_i & frame_addr));
  assign ready_held = ready_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      addr_q  <= 1'b0;
      ready_q <= 1'b0;
      fe_q    <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (rd_i) begin
        ready_q <= 1'b0;
        fe_q    <= 1'b0;
        ovr_q   <= 1'b0;
      end
      if (accept) begin
        if (ready_held) ovr_q <= 1'b1;
        else begin
          data_q  <= frame_data;
          addr_q  <= frame_addr;
          ready_q <= 1'b1;
          fe_q    <= ~frame_stop;
        end
      end
    end
  end

  assign data_o  = data_q;
  assign addr_o  = addr_q;
  assign ready_o = ready_q;
  assign fe_o    = fe_q;
  assign ovr_o   = ovr_q;
  assign sleep_o = sleep_q;
  assign irq_o   = ready_q & irq_en_i;
endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              sleep_set_i,
  input logic              wake_sel_i,
  input logic              sync_mode_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] data_o,
  input logic              ready_o,
  input logic              ovr_o,
  input logic              sleep_o,
  input logic              irq_o,
  input logic              frame_done_i,
  input logic              frame_addr_i
);
  p_irq_needs_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !irq_o);

  p_read_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !frame_done_i |=> !ready_o && !ovr_o);

  p_overrun_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && frame_done_i && !rd_i && !sleep_o |=> ovr_o && $stable(data_o));

  p_sleep_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_set_i && !soft_rst_i |=> sleep_o);

  p_soft_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !sleep_o);

  p_idle_sleep_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o && !wake_sel_i && !sync_mode_i && frame_done_i && !ready_o |=> !ready_o);

  p_addr_sleep_drops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o && wake_sel_i && !sync_mode_i && frame_done_i && !frame_addr_i && !ready_o
    |=> !ready_o);

  p_sync_delivers_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_i && frame_done_i && !ready_o |=> ready_o);
endmodule

bind mdrop_rx mdrop_rx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .sleep_set_i(sleep_set_i),
  .wake_sel_i(wake_sel_i), .sync_mode_i(sync_mode_i), .rd_i(rd_i), .data_o(data_o),
  .ready_o(ready_o), .ovr_o(ovr_o), .sleep_o(sleep_o), .irq_o(irq_o),
  .frame_done_i(frame_done), .frame_addr_i(frame_addr)
);

// File: tb/test_mdrop_rx.sv
module test_mdrop_rx;
  localparam int BITC = 32;  // clocks per bit: 16 ticks, one tick every 2 clocks

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic soft_rst = 0, rx = 1, rx_en = 1, wake_sel = 0, sync_mode = 0;
  logic sleep_set = 0, sleep_clr = 0, irq_en = 1, rd = 0;
  logic [7:0] data;
  logic addr, ready, fe, ovr, sleep, irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

  mdrop_rx i_mdrop_rx (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .tick_i(tick), .rx_i(rx),
    .rx_en_i(rx_en), .wake_sel_i(wake_sel), .sync_mode_i(sync_mode),
    .sleep_set_i(sleep_set), .sleep_clr_i(sleep_clr), .irq_en_i(irq_en), .rd_i(rd),
    .data_o(data), .addr_o(addr), .ready_o(ready), .fe_o(fe), .ovr_o(ovr),
    .sleep_o(sleep), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch: frame bit index to disturb for one tick; drop: bit index before which rx_en falls
  task automatic send(input logic [7:0] d, input logic a, input logic stp,
                      input int glitch = -1, input int drop = -1);
    logic [10:0] b;
    b = {stp, a, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      if (i == drop) rx_en = 1'b0;
      rx = b[i];
      if (i == glitch) begin
        clks(14); rx = ~b[i]; clks(2); rx = b[i]; clks(16);
      end else if (i == 10 && !stp) begin
        clks(20); rx = 1'b1; clks(12);
      end else clks(BITC);
    end
    rx = 1'b1;
    clks(4);
  endtask

  task automatic pulse_rd();
    rd = 1; clks(1); rd = 0; clks(1);
  endtask

  initial begin
    clks(190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clks(3);
    rst_n = 1;
    clks(4);
    chk("R1 reset ready", ready, 0);
    chk("R4 reset irq", irq, 0);
    chk("R3 reset fe", fe, 0);
    chk("R5 reset ovr", ovr, 0);
    chk("R7 reset sleep", sleep, 0);

    // R1/R4 sweep of data, marker bit and interrupt enable
    for (int i = 0; i < 64; i++) begin
      logic [7:0] d;
      d = 8'(i * 37 + 5);
      irq_en = i[1];
      send(d, i[0], 1'b1);
      chk("R1 data", data, d);
      chk("R1 addr", addr, i[0]);
      chk("R1 ready", ready, 1);
      chk("R3 no fe", fe, 0);
      chk("R4 irq", irq, i[1]);
      pulse_rd();
      chk("R4 read clears ready", ready, 0);
      chk("R4 irq after read", irq, 0);
    end
    irq_en = 1;

    // R3 framing error
    send(8'hC3, 1'b1, 1'b0);
    chk("R3 fe", fe, 1);
    chk("R3 data kept", data, 8'hC3);
    chk("R3 ready", ready, 1);
    clks(BITC);
    pulse_rd();
    chk("R4 read clears fe", fe, 0);
    chk("R2 no spurious frame after low stop", ready, 0);

    // R2 short start pulse
    rx = 0; clks(6); rx = 1; clks(2 * BITC);
    chk("R2 short pulse ignored", ready, 0);
    send(8'h96, 1'b0, 1'b1);
    chk("R2 next frame data", data, 8'h96);
    pulse_rd();

    // R11 majority vote on glitched bits
    send(8'h00, 1'b0, 1'b1, 4);
    chk("R11 high glitch", data, 8'h00);
    pulse_rd();
    send(8'hFF, 1'b1, 1'b1, 6);
    chk("R11 low glitch", data, 8'hFF);
    chk("R11 addr", addr, 1);
    pulse_rd();

    // R5 overrun
    send(8'h11, 1'b0, 1'b1);
    send(8'h22, 1'b1, 1'b1);
    chk("R5 ovr", ovr, 1);
    chk("R5 old data", data, 8'h11);
    chk("R5 old addr", addr, 0);
    chk("R5 ready", ready, 1);
    pulse_rd();
    chk("R4 read clears ovr", ovr, 0);
    chk("R4 read clears ready", ready, 0);

    // R6 enable
    rx_en = 0;
    send(8'h5A, 1'b0, 1'b1);
    chk("R6 disabled no frame", ready, 0);
    rx_en = 1;
    send(8'hA7, 1'b1, 1'b1, -1, 5);
    chk("R6 in-progress delivered", ready, 1);
    chk("R6 in-progress data", data, 8'hA7);
    chk("R4 irq with rx_en low", irq, 1);
    pulse_rd();
    chk("R4 read with rx_en low", ready, 0);
    send(8'h3C, 1'b0, 1'b1);
    chk("R6 still disabled", ready, 0);
    rx_en = 1;

    // R7 sleep flag control
    sleep_set = 1; clks(1); sleep_set = 0; clks(1);
    chk("R7 set", sleep, 1);
    sleep_clr = 1; clks(1); sleep_clr = 0; clks(1);
    chk("R7 clear", sleep, 0);
    sleep_set = 1; sleep_clr = 1; clks(1); sleep_set = 0; sleep_clr = 0; clks(1);
    chk("R7 set wins", sleep, 1);
    soft_rst = 1; sleep_set = 1; clks(1); soft_rst = 0; sleep_set = 0; clks(1);
    chk("R7 soft reset wins", sleep, 0);

    // R8 idle-line wake
    wake_sel = 0;
    sleep_set = 1; clks(1); sleep_set = 0;
    send(8'h01, 1'b1, 1'b1);
    send(8'h02, 1'b0, 1'b1);
    chk("R8 frames dropped", ready, 0);
    chk("R8 still asleep", sleep, 1);
    clks(8 * BITC);
    chk("R8 asleep after 8 bits idle", sleep, 1);
    clks(4 * BITC);
    chk("R8 woke on idle", sleep, 0);
    send(8'h77, 1'b0, 1'b1);
    chk("R8 next frame", ready, 1);
    chk("R8 next data", data, 8'h77);
    pulse_rd();

    // R9 address wake
    wake_sel = 1;
    sleep_set = 1; clks(1); sleep_set = 0;
    send(8'h44, 1'b0, 1'b1);
    chk("R9 non-address dropped", ready, 0);
    clks(12 * BITC);
    chk("R9 idle does not wake", sleep, 1);
    send(8'h5A, 1'b1, 1'b1);
    chk("R9 woke", sleep, 0);
    chk("R9 waking frame delivered", ready, 1);
    chk("R9 waking data", data, 8'h5A);
    chk("R9 waking addr", addr, 1);
    pulse_rd();
    send(8'h6B, 1'b0, 1'b1);
    chk("R9 rest of message", data, 8'h6B);
    pulse_rd();

    // R10 synchronous mode
    sync_mode = 1;
    sleep_set = 1; clks(1); sleep_set = 0;
    send(8'h81, 1'b0, 1'b1);
    chk("R10 delivered while flag set", ready, 1);
    chk("R10 data", data, 8'h81);
    pulse_rd();
    send(8'h82, 1'b1, 1'b1);
    chk("R10 address does not clear", sleep, 1);
    pulse_rd();
    wake_sel = 0;
    clks(12 * BITC);
    chk("R10 idle does not clear", sleep, 1);
    sync_mode = 0;
    sleep_clr = 1; clks(1); sleep_clr = 0; clks(1);
    chk("R7 forced wake", sleep, 0);
    send(8'h9E, 1'b1, 1'b1);
    chk("R7 frame after forced wake", data, 8'h9E);
    pulse_rd();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule